// File: doc/BRIEF.md
# Multiplexed External Memory Bus Sequencer

This block turns single internal read and write requests into cycles on an external bus where address and data share the same wires. Each request is accepted with a valid/ready handshake. It carries an address, a write flag, a byte-or-word size, an opcode-fetch flag and write data. The block then drives an address-latch strobe, read and write strobes, a byte-high lane select and an opcode-fetch indicator. It returns read data together with a single-cycle completion pulse.

The block runs on a clock whose period equals half an oscillator period. All strobe placement is counted in these half-period ticks. A two-bit mode input picks one of four strobe schedules. A two-bit width setting chooses among fixed 8-bit, fixed 16-bit, or a width taken per cycle from an input pin. On an 8-bit cycle, a word request is split into two byte cycles. A ready input stretches the strobe by whole wait states, up to a configured limit.

Two encodings are selectable. The latch pin can be a short latch pulse, or a low-active valid level that returns high at the end of every cycle. The write pins can be a plain write strobe with a byte-high select, or separate low-byte and high-byte write strobes.

Top module: `ext_bus_ctrl`

## Requirements
- R1: With mode 3 and no wait states, the latch pulse lasts 2 ticks. The read/write strobe is low for 2 ticks. It falls 4 ticks after the latch rises and returns high 6 ticks after the latch rises. The address goes onto the bus in the same tick the latch rises.
- R2: Mode 0 has the mode 3 schedule plus one wait state in every cycle, even with ready high. This gives a strobe low time of 6 ticks.
- R3: In mode 1, the strobe is low for 4 ticks. The latch still lasts 2 ticks but rises one tick earlier relative to the end of the strobe, which is 7 ticks after the latch rises. The address appears one tick after the latch rises.
- R4: Mode 2 has the mode 1 schedule, except that the address appears in the same tick the latch rises.
- R5: The width setting is a 2-bit value, with bit 1 written first. Setting 01 forces 8-bit cycles. Setting 10 forces 16-bit cycles. Setting 11 takes the width from the width pin during each cycle (low gives 8-bit, high gives 16-bit). A word request on an 8-bit cycle produces two bus cycles, at the even address and then at the odd one.
- R6: Width setting 00 is illegal and is handled as 16-bit. The first cycle run under it sets the error output, which then stays set until reset.
- R7: Byte lanes follow address bit 0 and the low-active byte-high select. An even byte gives A0=0 and select high. An odd byte gives A0=1 and select low. A word gives A0=0 and select low.
- R8: In split-strobe mode, the low-byte write strobe falls only when the even byte is written. The high-byte write strobe falls only when the odd byte is written, and both fall for a 16-bit word. In plain mode, the write strobe falls on every write. A read strobe and a write strobe are never low together.
- R9: The ready input is sampled before the strobe would end. While ready is low, one wait state of 4 ticks is added at a time, up to the configured maximum. With ready high, no wait state is added (except the forced one in mode 0).
- R10: In valid-level encoding, the latch pin is low from the start of the address phase to the end of the cycle, 6 ticks in mode 3. It is high whenever no cycle is in progress.
- R11: The opcode-fetch output is high for the whole of an external read marked as a fetch, 8 ticks for one cycle without waits. It is low for data reads and for all writes.
- R12: Read data is returned with a one-cycle completion pulse. A byte is returned in bits 7:0 with the upper bits zero. An odd byte on a 16-bit bus is taken from the high lane. Write data for a 16-bit word is driven on both lanes while the strobe is low.
- R13: After reset, the read and write strobes and the byte-high pin are high, the latch pin is inactive, the bus is not driven, the request-ready output is high, and the error output and the completion pulse are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-oscillator-period tick clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | Strobe schedule select (0..3) |
| cfg_width | input | 2 | Bus width setting |
| cfg_adv | input | 1 | 1: latch pin is low-active valid level; 0: latch pulse |
| cfg_split | input | 1 | 1: separate low/high write strobes |
| cfg_wait_max | input | WAIT_W | Maximum wait states per cycle |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | AW | Byte address (words even) |
| req_wr | input | 1 | 1: write, 0: read |
| req_word | input | 1 | 1: 16-bit word, 0: byte |
| req_fetch | input | 1 | Read is an opcode fetch |
| req_wdata | input | DW | Write data (byte in bits 7:0) |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DW | Read data |
| cfg_err | output | 1 | Sticky illegal-width flag |
| bus_ad_out | output | DW | Multiplexed address/data out |
| bus_ad_oe | output | 1 | Drive enable for the shared bus |
| bus_ad_in | input | DW | Multiplexed data in |
| bus_a_hi | output | AW-DW | Upper address bits |
| bus_ale | output | 1 | Latch pulse or low-active valid level |
| bus_rd_n | output | 1 | Read strobe, low active |
| bus_wr_n | output | 1 | Write strobe or low-byte write strobe |
| bus_bhe_n | output | 1 | Byte-high select or high-byte write strobe |
| bus_inst | output | 1 | Opcode-fetch indicator |
| bus_ready | input | 1 | External ready, low stretches the cycle |
| bus_width16 | input | 1 | Per-cycle width pin, high is 16-bit |

## Verification
The assertions assume that the mode, width, encoding and wait-limit settings change only while no request is in flight. They also assume that word requests use an even address. The bench writes all settings between transactions, after the completion pulse, and lets two clocks pass before it clears its measurements. The ready and width pins are held at one level for the whole of each transaction, so each wait count can be predicted from the limit alone. Every request the bench issues uses an even address for words.

// File: rtl/ebc_pkg.sv
package ebc_pkg;
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_WAIT} seq_st_t;

  localparam int TICK_W = 3;
  localparam logic [TICK_W-1:0] T_WID      = 3'd2;
  localparam logic [TICK_W-1:0] T_ADDR_END = 3'd3;
  localparam logic [TICK_W-1:0] T_DATA     = 3'd4;
  localparam logic [TICK_W-1:0] T_SAMP     = 3'd5;
  localparam logic [TICK_W-1:0] T_LAST_STB = 3'd6;
  localparam logic [TICK_W-1:0] T_END      = 3'd7;
  localparam int WAIT_TICKS = 4;

  typedef struct packed {
    logic [TICK_W-1:0] ale_first;
    logic [TICK_W-1:0] addr_first;
    logic [TICK_W-1:0] stb_first;
  } phase_t;

  function automatic phase_t phase_of(input logic [1:0] mode);
    phase_t p;
    case (mode)
      2'd1:    begin p.ale_first = 3'd0; p.addr_first = 3'd1; p.stb_first = 3'd3; end
      2'd2:    begin p.ale_first = 3'd0; p.addr_first = 3'd0; p.stb_first = 3'd3; end
      default: begin p.ale_first = 3'd1; p.addr_first = 3'd1; p.stb_first = 3'd5; end
    endcase
    return p;
  endfunction
endpackage

// File: rtl/ebc_width.sv
module ebc_width (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] cfg_width,
  input  logic       width_pin,
  input  logic       sample,
  output logic       is16,
  output logic       err
);
  always_comb begin
    case (cfg_width)
      2'b01:   is16 = 1'b0;
      2'b11:   is16 = width_pin;
      default: is16 = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) err <= 1'b0;
    else if (sample && cfg_width == 2'b00) err <= 1'b1;
  end

  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst) err |=> err);
endmodule

// File: rtl/ebc_seq.sv
module ebc_seq import ebc_pkg::*; #(
  parameter int WAIT_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        mode,
  input  logic [WAIT_W-1:0] wait_max,
  input  logic              ready,
  input  logic              word,
  input  logic              is16,
  output seq_st_t           st,
  output logic [TICK_W-1:0] tick,
  output logic              second,
  output logic              bus16,
  output logic              done,
  output logic              cap,
  output logic              wsample
);
  localparam int SUB_W = $clog2(WAIT_TICKS);

  logic [WAIT_W-1:0] wcnt, cap_lim;
  logic [SUB_W-1:0]  wsub;
  logic              want_wait, force_w;

  always_comb begin
    cap_lim   = (mode == 2'd0 && wait_max == '0) ? WAIT_W'(1) : wait_max;
    force_w   = (mode == 2'd0) && (wcnt == '0);
    want_wait = (wcnt < cap_lim) && (!ready || force_w);
    cap       = (st == S_RUN) && (tick == T_LAST_STB);
    wsample   = (st == S_RUN) && (tick == T_WID);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; tick <= '0; wcnt <= '0; wsub <= '0;
      second <= 1'b0; bus16 <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st <= S_RUN; tick <= '0; wcnt <= '0; second <= 1'b0;
        end
        S_RUN: begin
          if (tick == T_WID) bus16 <= is16;
          if (tick == T_SAMP && want_wait) begin
            st <= S_WAIT; wsub <= '0; wcnt <= wcnt + 1'b1;
          end else if (tick == T_END) begin
            if (word && !bus16 && !second) begin
              second <= 1'b1; tick <= '0; wcnt <= '0;
            end else begin
              st <= S_IDLE; done <= 1'b1;
            end
          end else begin
            tick <= tick + 1'b1;
          end
        end
        S_WAIT: begin
          if (wsub == SUB_W'(WAIT_TICKS - 1)) begin
            if (want_wait) begin
              wsub <= '0; wcnt <= wcnt + 1'b1;
            end else begin
              st <= S_RUN; tick <= T_SAMP + 1'b1;
            end
          end else begin
            wsub <= wsub + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R9
  ready_nowait_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_RUN && tick == T_SAMP && ready && mode != 2'd0) |=> (st == S_RUN));
  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R9
  wait_limit_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_WAIT && mode != 2'd0) |-> (wcnt <= wait_max));
endmodule

// File: rtl/ebc_pins.sv
module ebc_pins import ebc_pkg::*; #(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  seq_st_t           st,
  input  logic [TICK_W-1:0] tick,
  input  logic              second,
  input  logic              bus16,
  input  logic [1:0]        mode,
  input  logic              adv_en,
  input  logic              split_en,
  input  logic [AW-1:0]     addr,
  input  logic              wr,
  input  logic              word,
  input  logic              fetch,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     ad_out,
  output logic              ad_oe,
  output logic [AW-DW-1:0]  a_hi,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic              bhe_n,
  output logic              inst
);
  localparam int LW = DW / 2;

  phase_t        ph;
  logic          run, wt, active;
  logic          ale_win, adv_win, addr_win, stb_win, data_win;
  logic          cur_a0, full16, lo_lane, hi_lane, bhe_lane_n;
  logic [DW-1:0] dval;

  always_comb begin
    ph       = phase_of(mode);
    run      = (st == S_RUN);
    wt       = (st == S_WAIT);
    active   = run || wt;
    ale_win  = run && tick >= ph.ale_first && tick <= ph.ale_first + 3'd1;
    adv_win  = (run && tick >= ph.ale_first && tick <= T_LAST_STB) || wt;
    addr_win = run && tick >= ph.addr_first && tick <= T_ADDR_END;
    stb_win  = (run && tick >= ph.stb_first && tick <= T_LAST_STB) || wt;
    data_win = wr && ((run && tick >= T_DATA) || wt);
    cur_a0   = second | addr[0];
    full16   = word && !second && bus16;
    lo_lane  = !cur_a0;
    hi_lane  = cur_a0 || full16;
    bhe_lane_n = !(cur_a0 || (word && !second));
    if (full16)              dval = wdata;
    else if (word && second) dval = {2{wdata[DW-1:LW]}};
    else                     dval = {2{wdata[LW-1:0]}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ad_out <= '0; ad_oe <= 1'b0; a_hi <= '0; ale <= adv_en;
      rd_n <= 1'b1; wr_n <= 1'b1; bhe_n <= 1'b1; inst <= 1'b0;
    end else begin
      ad_out <= addr_win ? {addr[DW-1:1], cur_a0} : (data_win ? dval : '0);
      ad_oe  <= addr_win || data_win;
      a_hi   <= active ? addr[AW-1:DW] : '0;
      ale    <= adv_en ? !adv_win : ale_win;
      rd_n   <= !(stb_win && !wr);
      inst   <= active && fetch && !wr;
      if (split_en) begin
        wr_n  <= !(stb_win && wr && lo_lane);
        bhe_n <= !(stb_win && wr && hi_lane);
      end else begin
        wr_n  <= !(stb_win && wr);
        bhe_n <= active ? bhe_lane_n : 1'b1;
      end
    end
  end

  // R8
  no_rdwr_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> (wr_n && (bhe_n || !split_en)));
  // R11
  inst_read_only_chk: assert property (@(posedge clk) disable iff (rst) inst |-> wr_n);
  // R10
  adv_idle_high_chk: assert property (@(posedge clk) disable iff (rst)
    (adv_en && $past(adv_en) && $past(st) == S_IDLE) |-> ale);
endmodule

// File: rtl/ext_bus_ctrl.sv
module ext_bus_ctrl import ebc_pkg::*; #(
  parameter int AW     = 20,
  parameter int DW     = 16,
  parameter int WAIT_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cfg_mode,
  input  logic [1:0]        cfg_width,
  input  logic              cfg_adv,
  input  logic              cfg_split,
  input  logic [WAIT_W-1:0] cfg_wait_max,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [AW-1:0]     req_addr,
  input  logic              req_wr,
  input  logic              req_word,
  input  logic              req_fetch,
  input  logic [DW-1:0]     req_wdata,
  output logic              rsp_done,
  output logic [DW-1:0]     rsp_rdata,
  output logic              cfg_err,
  output logic [DW-1:0]     bus_ad_out,
  output logic              bus_ad_oe,
  input  logic [DW-1:0]     bus_ad_in,
  output logic [AW-DW-1:0]  bus_a_hi,
  output logic              bus_ale,
  output logic              bus_rd_n,
  output logic              bus_wr_n,
  output logic              bus_bhe_n,
  output logic              bus_inst,
  input  logic              bus_ready,
  input  logic              bus_width16
);
  localparam int LW = DW / 2;

  seq_st_t           st;
  logic [TICK_W-1:0] tick;
  logic              second, bus16, cap, wsample, is16, accept;
  logic [AW-1:0]     r_addr;
  logic              r_wr, r_word, r_fetch;
  logic [DW-1:0]     r_wdata, r_rbuf;

  assign req_ready = (st == S_IDLE);
  assign accept    = req_valid && req_ready;
  assign rsp_rdata = r_rbuf;

  always_ff @(posedge clk) begin
    if (rst) begin
      r_addr <= '0; r_wr <= 1'b0; r_word <= 1'b0; r_fetch <= 1'b0;
      r_wdata <= '0; r_rbuf <= '0;
    end else if (accept) begin
      r_addr <= req_addr; r_wr <= req_wr; r_word <= req_word;
      r_fetch <= req_fetch; r_wdata <= req_wdata; r_rbuf <= '0;
    end else if (cap && !r_wr) begin
      if (!second && r_word && bus16) r_rbuf <= bus_ad_in;
      else if (second)                r_rbuf[DW-1:LW] <= bus_ad_in[LW-1:0];
      else if (bus16 && r_addr[0])    r_rbuf[LW-1:0]  <= bus_ad_in[DW-1:LW];
      else                            r_rbuf[LW-1:0]  <= bus_ad_in[LW-1:0];
    end
  end

  ebc_width i_width (
    .clk(clk), .rst(rst), .cfg_width(cfg_width), .width_pin(bus_width16),
    .sample(wsample), .is16(is16), .err(cfg_err)
  );

  ebc_seq #(.WAIT_W(WAIT_W)) i_seq (
    .clk(clk), .rst(rst), .start(accept), .mode(cfg_mode), .wait_max(cfg_wait_max),
    .ready(bus_ready), .word(r_word), .is16(is16), .st(st), .tick(tick),
    .second(second), .bus16(bus16), .done(rsp_done), .cap(cap), .wsample(wsample)
  );

  ebc_pins #(.AW(AW), .DW(DW)) i_pins (
    .clk(clk), .rst(rst), .st(st), .tick(tick), .second(second), .bus16(bus16),
    .mode(cfg_mode), .adv_en(cfg_adv), .split_en(cfg_split), .addr(r_addr),
    .wr(r_wr), .word(r_word), .fetch(r_fetch), .wdata(r_wdata),
    .ad_out(bus_ad_out), .ad_oe(bus_ad_oe), .a_hi(bus_a_hi), .ale(bus_ale),
    .rd_n(bus_rd_n), .wr_n(bus_wr_n), .bhe_n(bus_bhe_n), .inst(bus_inst)
  );
endmodule

// File: tb/test_ext_bus_ctrl.sv
module test_ext_bus_ctrl;
  logic clk = 1'b0, rst = 1'b1;
  logic [1:0] cfg_mode = 2'd3, cfg_width = 2'b10;
  logic cfg_adv = 1'b0, cfg_split = 1'b0;
  logic [2:0] cfg_wait_max = 3'd0;
  logic req_valid = 1'b0, req_wr = 1'b0, req_word = 1'b0, req_fetch = 1'b0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0, ad_in = '0;
  logic ready = 1'b1, wpin = 1'b1;
  logic req_ready, rsp_done, cfg_err, ad_oe, ale, rd_n, wr_n, bhe_n, inst;
  logic [15:0] rsp_rdata, ad_out;
  logic [3:0] a_hi;

  always #2 clk = ~clk;

  ext_bus_ctrl i_ext_bus_ctrl (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_width(cfg_width), .cfg_adv(cfg_adv),
    .cfg_split(cfg_split), .cfg_wait_max(cfg_wait_max), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .req_wr(req_wr), .req_word(req_word),
    .req_fetch(req_fetch), .req_wdata(req_wdata), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .cfg_err(cfg_err), .bus_ad_out(ad_out), .bus_ad_oe(ad_oe), .bus_ad_in(ad_in),
    .bus_a_hi(a_hi), .bus_ale(ale), .bus_rd_n(rd_n), .bus_wr_n(wr_n), .bus_bhe_n(bhe_n),
    .bus_inst(inst), .bus_ready(ready), .bus_width16(wpin)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  int ale_cur, ale_w, stb_cur, stb_w, n_ale, t_ale_r, t_stb_f, t_stb_e, t_oe, inst_cnt;
  logic p_ale = 1'b0, p_stb = 1'b0, p_oe = 1'b0, ale_a, stb_a;
  logic [15:0] addr_seen, data_seen, rd_val;
  logic bhe_seen, wrl_seen, wrh_seen, rd_seen;

  // Bus monitor and memory responder, sampled just after each rising edge
  always begin
    @(posedge clk); #1;
    cyc++;
    ale_a = cfg_adv ? !ale : ale;
    stb_a = !rd_n || !wr_n || (cfg_split && !bhe_n);
    if (ale_a && !p_ale) begin n_ale++; t_ale_r = cyc; end
    if (ale_a) ale_cur++;
    else if (p_ale) begin
      ale_w = ale_cur; ale_cur = 0;
      if (!cfg_adv) begin
        addr_seen = ad_out; bhe_seen = bhe_n; ad_in = {~ad_out[7:0], ad_out[7:0]};
      end
    end
    if (stb_a && !p_stb) begin t_stb_f = cyc; data_seen = ad_out; end
    if (stb_a) stb_cur++;
    else if (p_stb) begin stb_w = stb_cur; stb_cur = 0; t_stb_e = cyc; end
    if (ad_oe && !p_oe) t_oe = cyc;
    if (!wr_n) wrl_seen = 1'b1;
    if (cfg_split && !bhe_n) wrh_seen = 1'b1;
    if (!rd_n) rd_seen = 1'b1;
    if (inst) inst_cnt++;
    p_ale = ale_a; p_stb = stb_a; p_oe = ad_oe;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish (actual cyc=%0d, expected < 150000)", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, got, exp);
    end
  endtask

  task automatic clr();
    ale_cur = 0; ale_w = 0; stb_cur = 0; stb_w = 0; n_ale = 0; t_ale_r = 0;
    t_stb_f = 0; t_stb_e = 0; t_oe = 0; inst_cnt = 0; addr_seen = '0; data_seen = '0;
    bhe_seen = 1'b1; wrl_seen = 1'b0; wrh_seen = 1'b0; rd_seen = 1'b0;
  endtask

  task automatic setup(input logic [1:0] m, input logic [1:0] w, input logic adv,
                       input logic split, input logic [2:0] wmax);
    @(negedge clk);
    cfg_mode = m; cfg_width = w; cfg_adv = adv; cfg_split = split; cfg_wait_max = wmax;
    repeat (2) @(negedge clk);
    clr();
  endtask

  task automatic txn(input logic [19:0] a, input logic w, input logic wd,
                     input logic f, input logic [15:0] d);
    @(negedge clk);
    req_addr = a; req_wr = w; req_word = wd; req_fetch = f; req_wdata = d; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1 req_valid = 1'b0;
    @(negedge clk);
    while (!rsp_done) @(negedge clk);
    rd_val = rsp_rdata;
  endtask

  task automatic t_reset();
    chk("R13 rd_n", int'(rd_n), 1); chk("R13 wr_n", int'(wr_n), 1);
    chk("R13 bhe_n", int'(bhe_n), 1); chk("R13 ale", int'(ale), 0);
    chk("R13 ad_oe", int'(ad_oe), 0); chk("R13 req_ready", int'(req_ready), 1);
    chk("R13 err", int'(cfg_err), 0); chk("R13 done", int'(rsp_done), 0);
  endtask

  task automatic t_mode3();
    setup(2'd3, 2'b10, 1'b0, 1'b0, 3'd0);
    txn(20'h00140, 1'b0, 1'b0, 1'b0, 16'h0);
    chk("R1 ale width", ale_w, 2); chk("R1 strobe width", stb_w, 2);
    chk("R1 strobe fall offset", t_stb_f - t_ale_r, 4);
    chk("R1 strobe end offset", t_stb_e - t_ale_r, 6);
    chk("R1 address offset", t_oe - t_ale_r, 0);
    chk("R12 even byte data", int'(rd_val), 16'h0040);
  endtask

  task automatic t_mode1();
    setup(2'd1, 2'b10, 1'b0, 1'b0, 3'd0);
    txn(20'h00140, 1'b0, 1'b0, 1'b0, 16'h0);
    chk("R3 ale width", ale_w, 2); chk("R3 strobe width", stb_w, 4);
    chk("R3 strobe end offset", t_stb_e - t_ale_r, 7);
    chk("R3 address offset", t_oe - t_ale_r, 1);
  endtask

  task automatic t_mode2();
    setup(2'd2, 2'b10, 1'b0, 1'b0, 3'd0);
    txn(20'h00140, 1'b0, 1'b0, 1'b0, 16'h0);
    chk("R4 strobe width", stb_w, 4);
    chk("R4 strobe end offset", t_stb_e - t_ale_r, 7);
    chk("R4 address offset", t_oe - t_ale_r, 0);
  endtask

  task automatic t_mode0();
    setup(2'd0, 2'b10, 1'b0, 1'b0, 3'd0);
    ready = 1'b1;
    txn(20'h00140, 1'b0, 1'b0, 1'b0, 16'h0);
    chk("R2 forced wait strobe width", stb_w, 6);
    chk("R2 ale width", ale_w, 2);
  endtask

  task automatic t_ready(input logic [1:0] m, input logic [2:0] wmax, input int exp);
    setup(m, 2'b10, 1'b0, 1'b0, wmax);
    ready = 1'b0;
    txn(20'h00140, 1'b0, 1'b0, 1'b0, 16'h0);
    ready = 1'b1;
    chk("R9 wait-stretched strobe width", stb_w, exp);
  endtask

  task automatic t_width(input logic [1:0] w, input logic pin, input int cycles, input int data);
    setup(2'd3, w, 1'b0, 1'b0, 3'd0);
    wpin = pin;
    txn(20'h00120, 1'b0, 1'b1, 1'b0, 16'h0);
    wpin = 1'b1;
    chk("R5 bus cycles per word", n_ale, cycles);
    chk("R5 word read data", int'(rd_val), data);
  endtask

  task automatic t_lanes();
    setup(2'd3, 2'b10, 1'b0, 1'b0, 3'd0);
    txn(20'h00132, 1'b0, 1'b0, 1'b0, 16'h0);
    chk("R7 even byte bhe_n", int'(bhe_seen), 1); chk("R7 even byte a0", int'(addr_seen[0]), 0);
    chk("R12 even byte data", int'(rd_val), 16'h0032);
    clr();
    txn(20'h00133, 1'b0, 1'b0, 1'b0, 16'h0);
    chk("R7 odd byte bhe_n", int'(bhe_seen), 0); chk("R7 odd byte a0", int'(addr_seen[0]), 1);
    chk("R12 odd byte from high lane", int'(rd_val), 16'h00CC);
    clr();
    txn(20'h00132, 1'b0, 1'b1, 1'b0, 16'h0);
    chk("R7 word bhe_n", int'(bhe_seen), 0); chk("R7 word a0", int'(addr_seen[0]), 0);
  endtask

  task automatic t_writes();
    setup(2'd3, 2'b10, 1'b0, 1'b0, 3'd0);
    txn(20'h00150, 1'b1, 1'b1, 1'b0, 16'hBEEF);
    chk("R8 plain write strobe", int'(wrl_seen), 1); chk("R8 no read strobe", int'(rd_seen), 0);
    chk("R12 word write data", int'(data_seen), 16'hBEEF);
    setup(2'd3, 2'b10, 1'b0, 1'b1, 3'd0);
    txn(20'h00150, 1'b1, 1'b0, 1'b0, 16'h0011);
    chk("R8 even write low strobe", int'(wrl_seen), 1); chk("R8 even write high strobe", int'(wrh_seen), 0);
    clr();
    txn(20'h00151, 1'b1, 1'b0, 1'b0, 16'h0022);
    chk("R8 odd write low strobe", int'(wrl_seen), 0); chk("R8 odd write high strobe", int'(wrh_seen), 1);
    clr();
    txn(20'h00150, 1'b1, 1'b1, 1'b0, 16'h3344);
    chk("R8 word write low strobe", int'(wrl_seen), 1); chk("R8 word write high strobe", int'(wrh_seen), 1);
  endtask

  task automatic t_inst();
    setup(2'd3, 2'b10, 1'b0, 1'b0, 3'd0);
    txn(20'h00160, 1'b0, 1'b1, 1'b1, 16'h0);
    chk("R11 fetch flag ticks", inst_cnt, 8);
    clr();
    txn(20'h00160, 1'b0, 1'b1, 1'b0, 16'h0);
    chk("R11 data read flag ticks", inst_cnt, 0);
    clr();
    txn(20'h00160, 1'b1, 1'b1, 1'b1, 16'h5555);
    chk("R11 write flag ticks", inst_cnt, 0);
  endtask

  task automatic t_adv();
    setup(2'd3, 2'b10, 1'b1, 1'b0, 3'd0);
    txn(20'h00170, 1'b0, 1'b0, 1'b0, 16'h0);
    chk("R10 valid-level low width", ale_w, 6);
    @(negedge clk);
    chk("R10 valid-level high when idle", int'(ale), 1);
  endtask

  task automatic t_illegal();
    chk("R6 error clear before use", int'(cfg_err), 0);
    setup(2'd3, 2'b00, 1'b0, 1'b0, 3'd0);
    txn(20'h00120, 1'b0, 1'b1, 1'b0, 16'h0);
    chk("R6 illegal width runs 16-bit", n_ale, 1);
    @(negedge clk);
    chk("R6 error set", int'(cfg_err), 1);
    setup(2'd3, 2'b10, 1'b0, 1'b0, 3'd0);
    txn(20'h00120, 1'b0, 1'b1, 1'b0, 16'h0);
    @(negedge clk);
    chk("R6 error sticky", int'(cfg_err), 1);
  endtask

  initial begin
    clr();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_mode3();
    t_mode1();
    t_mode2();
    t_mode0();
    t_ready(2'd3, 3'd2, 10);
    t_ready(2'd3, 3'd0, 2);
    t_ready(2'd0, 3'd0, 6);
    t_ready(2'd0, 3'd3, 14);
    t_width(2'b01, 1'b1, 2, 16'h2120);
    t_width(2'b10, 1'b0, 1, 16'hDF20);
    t_width(2'b11, 1'b0, 2, 16'h2120);
    t_width(2'b11, 1'b1, 1, 16'hDF20);
    t_lanes();
    t_writes();
    t_inst();
    t_adv();
    t_illegal();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule